// File: doc/BRIEF.md
# Radix Page Tree Walker

This block turns a 64-bit effective address into a real address by walking a radix page tree held in memory. A request carries the effective page number (address bits 63 to 12) and a process ID. A table configuration input gives the process-table base and its size field. The walker reads the process-table entry and checks the root of the tree against the address. It then follows page-directory entries down the tree until it reaches a leaf, or until it finds a fault.

The walker uses a single-beat 64-bit read port. It holds the request and its address until the memory side acknowledges, and each acknowledge returns the data in the same cycle. Only one read is in flight at a time. At the end of a walk, `done` pulses for one cycle. With that pulse come either a real address and a zero error code, or an error code and a zero address. A new request is taken only while `req_ready` is high.

Top module: `radix_walker`

## Requirements
- R1: The first read address is `{8'b0, base[55:36], merged[35:12], pid[7:0], 4'b0}`, where `base` is `tbl_base` placed at bits 55:12. `merged` takes `pid[31:8]` on the lowest `tbl_size` bit positions (at most 24) and the base bits elsewhere.
- R2: When effective address bit 63 is set, the process ID used in R1 is zero.
- R3: The root entry holds a 5-bit tree size. Its upper two bits sit at entry bits 62:61 and its lower three bits at entry bits 7:5, and the tree spans size+31 address bits. The walk ends with error code 1 (segment) when address bits 63 and 62 differ. It also ends with code 1 when any address bit from 61 down to 31+size is set.
- R4: An index width (entry bits 4:0) below 5, above 16, or above the remaining shift ends the walk with error code 2 (bad tree). This check applies at the root and at every non-leaf directory entry.
- R5: After the root, the remaining shift is tree size + 19 − root index width. Each further non-leaf level subtracts its own index width.
- R6: A directory read address is `{8'b0, B[55:19], F, 3'b0}`, where `B` is the level base. `F` takes `(va[60:12] >> shift)` on its lowest index-width bits and `B[18:3]` elsewhere.
- R7: In a directory entry, bit 63 is valid and bit 62 is leaf, and bits 55:8 with eight zero bits appended give the next level base. The root entry's base comes from the same bits. An entry with bit 63 clear ends the walk with error code 3 (no entry).
- R8: For a leaf, real address bits 55:12 take address bits where the lowest `shift` bit positions lie and entry bits elsewhere. Bits 11:0 come from the entry and bits 63:56 are zero.
- R9: `mem_req` stays high with `mem_addr` unchanged until `mem_ack`, and at most one read is in flight.
- R10: `done` is a one-cycle pulse. On success `err` is 0 and `real_addr` is valid; on error `real_addr` is 0.
- R11: `req_ready` is high only when the walker is idle, including after reset. A `req_valid` seen while busy has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request taken |
| req_vpn | input | 52 | Effective address bits 63:12 |
| req_pid | input | 32 | Process ID |
| tbl_base | input | 44 | Process-table base, address bits 55:12 |
| tbl_size | input | 5 | Process-table size field |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 64 | Read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | Walk finished pulse |
| real_addr | output | 64 | Translated real address |
| err | output | 2 | 0 ok, 1 segment, 2 bad tree, 3 no entry |

## Verification
The assertions assume that `mem_ack` comes only while `mem_req` is high and lasts one cycle per read. They also assume that `rst` is held from time zero until the first edges have passed. The bench's memory model follows both rules: it answers each held request after a fixed latency with a single-cycle acknowledge, then drops it. Requests are offered only while the walker is idle, except in the one scenario that deliberately drives a request during a walk.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

    localparam int VPN_W     = 52;
    localparam int PID_W     = 32;
    localparam int PTE_W     = 64;
    localparam int ADDR_W    = 64;
    localparam int TBASE_W   = 44;
    localparam int SIZE_W    = 5;
    localparam int SHIFT_W   = 6;
    localparam int NLB_W     = 48;
    localparam int IDX_MIN   = 5;
    localparam int IDX_MAX   = 16;
    localparam int IDX_W     = IDX_MAX;
    localparam int TREE_BIAS = 19;
    localparam int PT_MASK_W = 24;
    localparam int SEG_W     = 31;
    localparam int SEG_IN_W  = SEG_W + 2;
    localparam int VLO_W     = 49;
    localparam int PA_PG_W   = 44;

    typedef enum logic [1:0] {
        WALK_OK       = 2'd0,
        WALK_SEG_ERR  = 2'd1,
        WALK_BAD_TREE = 2'd2,
        WALK_NO_ENTRY = 2'd3
    } walk_err_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TBL_FETCH,
        S_ROOT_CHK,
        S_DIR_FETCH,
        S_DIR_EVAL,
        S_REPORT
    } walk_state_e;

    typedef struct packed {
        logic              valid;
        logic              leaf;
        logic [NLB_W-1:0]  next_base;
        logic [SIZE_W-1:0] idx_bits;
        logic [SIZE_W-1:0] tree_sz;
    } entry_view_t;

    function automatic logic [63:0] ones_below(input logic [6:0] n);
        if (n >= 7'd64)
            return '1;
        return (64'd1 << n) - 64'd1;
    endfunction

    function automatic entry_view_t view_entry(input logic [PTE_W-1:0] e);
        entry_view_t v;
        v.valid     = e[63];
        v.leaf      = e[62];
        v.next_base = e[55:8];
        v.idx_bits  = e[4:0];
        v.tree_sz   = {e[62:61], e[7:5]};
        return v;
    endfunction

endpackage

// File: rtl/radix_addr_gen.sv
module radix_addr_gen
    import radix_walk_pkg::*;
(
    input  logic [TBASE_W-1:0] tbl_base,
    input  logic [SIZE_W-1:0]  tbl_size,
    input  logic [PID_W-1:0]   pid,
    input  logic [VLO_W-1:0]   va_lo,
    input  logic [NLB_W-1:0]   lvl_base,
    input  logic [SIZE_W-1:0]  idx_bits,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [55:0]        leaf_ent,
    output logic [ADDR_W-1:0]  tbl_addr,
    output logic [ADDR_W-1:0]  dir_addr,
    output logic [ADDR_W-1:0]  leaf_addr
);
    logic [PT_MASK_W-1:0] pt_mask;
    logic [PT_MASK_W-1:0] pt_mid;
    logic [IDX_W-1:0]     idx_mask;
    logic [VLO_W-1:0]     va_sh;
    logic [IDX_W-1:0]     idx_field;
    logic [IDX_W-1:0]     base_field;
    logic [PA_PG_W-1:0]   pg_mask;
    logic [PA_PG_W-1:0]   pg_num;
    logic [63:0]          m_pt, m_idx, m_pg;

    always_comb begin
        m_pt     = ones_below({2'b0, tbl_size});
        pt_mask  = m_pt[PT_MASK_W-1:0];
        pt_mid   = (tbl_base[PT_MASK_W-1:0] & ~pt_mask) |
                   (pid[PID_W-1:8] & pt_mask);
        tbl_addr = {8'b0, tbl_base[TBASE_W-1:PT_MASK_W], pt_mid, pid[7:0], 4'b0};
    end

    always_comb begin
        m_idx      = ones_below({2'b0, idx_bits});
        idx_mask   = m_idx[IDX_W-1:0];
        va_sh      = va_lo >> shift;
        base_field = {lvl_base[10:0], 5'b0};
        idx_field  = (base_field & ~idx_mask) | (va_sh[IDX_W-1:0] & idx_mask);
        dir_addr   = {8'b0, lvl_base[NLB_W-1:11], idx_field, 3'b0};
    end

    always_comb begin
        m_pg      = ones_below({1'b0, shift});
        pg_mask   = m_pg[PA_PG_W-1:0];
        pg_num    = (leaf_ent[55:12] & ~pg_mask) | (va_lo[PA_PG_W-1:0] & pg_mask);
        leaf_addr = {8'b0, pg_num, leaf_ent[11:0]};
    end

endmodule

// File: rtl/radix_level_check.sv
module radix_level_check
    import radix_walk_pkg::*;
(
    input  logic                is_root,
    input  logic [SIZE_W-1:0]   tree_sz,
    input  logic [SIZE_W-1:0]   idx_bits,
    input  logic [SHIFT_W-1:0]  shift_in,
    input  logic [SEG_IN_W-1:0] seg_bits,
    output logic                seg_fail,
    output logic                tree_fail,
    output logic [SHIFT_W-1:0]  shift_out
);
    logic [SHIFT_W-1:0] limit;
    logic [SHIFT_W-1:0] idx_ext;
    logic [SEG_W-1:0]   covered;
    logic [63:0]        m_seg;
    logic               top_mismatch;
    logic               stray_bits;

    always_comb begin
        m_seg        = ones_below({2'b0, tree_sz});
        covered      = m_seg[SEG_W-1:0];
        top_mismatch = seg_bits[SEG_IN_W-1] != seg_bits[SEG_IN_W-2];
        stray_bits   = |(seg_bits[SEG_W-1:0] & ~covered);
        seg_fail     = is_root && (top_mismatch || stray_bits);

        idx_ext   = {1'b0, idx_bits};
        limit     = is_root ? ({1'b0, tree_sz} + SHIFT_W'(TREE_BIAS)) : shift_in;
        tree_fail = !seg_fail &&
                    ((idx_ext < SHIFT_W'(IDX_MIN)) ||
                     (idx_ext > SHIFT_W'(IDX_MAX)) ||
                     (idx_ext > limit));
        shift_out = limit - idx_ext;
    end

endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import radix_walk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [PID_W-1:0]   req_pid,
    input  logic [TBASE_W-1:0] tbl_base,
    input  logic [SIZE_W-1:0]  tbl_size,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_ack,
    input  logic [PTE_W-1:0]   mem_rdata,
    output logic               done,
    output logic [ADDR_W-1:0]  real_addr,
    output logic [1:0]         err
);
    walk_state_e        state;
    logic [VPN_W-1:0]   vpn_r;
    logic [PID_W-1:0]   pid_r;
    logic [TBASE_W-1:0] tbase_r;
    logic [SIZE_W-1:0]  tsize_r;
    logic [PTE_W-1:0]   entry_r;
    logic [NLB_W-1:0]   base_r;
    logic [SIZE_W-1:0]  idx_r;
    logic [SHIFT_W-1:0] shift_r;
    logic [ADDR_W-1:0]  pa_r;
    walk_err_e          err_r;

    entry_view_t        ev;
    logic [ADDR_W-1:0]  tbl_addr, dir_addr, leaf_addr;
    logic               seg_fail, tree_fail;
    logic [SHIFT_W-1:0] shift_next;

    assign ev = view_entry(entry_r);

    radix_addr_gen u_addr (
        .tbl_base  (tbase_r),
        .tbl_size  (tsize_r),
        .pid       (pid_r),
        .va_lo     (vpn_r[VLO_W-1:0]),
        .lvl_base  (base_r),
        .idx_bits  (idx_r),
        .shift     (shift_r),
        .leaf_ent  (entry_r[55:0]),
        .tbl_addr  (tbl_addr),
        .dir_addr  (dir_addr),
        .leaf_addr (leaf_addr)
    );

    radix_level_check u_chk (
        .is_root   (state == S_ROOT_CHK),
        .tree_sz   (ev.tree_sz),
        .idx_bits  (ev.idx_bits),
        .shift_in  (shift_r),
        .seg_bits  (vpn_r[VPN_W-1:VPN_W-SEG_IN_W]),
        .seg_fail  (seg_fail),
        .tree_fail (tree_fail),
        .shift_out (shift_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            vpn_r   <= '0;
            pid_r   <= '0;
            tbase_r <= '0;
            tsize_r <= '0;
            entry_r <= '0;
            base_r  <= '0;
            idx_r   <= '0;
            shift_r <= '0;
            pa_r    <= '0;
            err_r   <= WALK_OK;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        vpn_r   <= req_vpn;
                        pid_r   <= req_vpn[VPN_W-1] ? '0 : req_pid;
                        tbase_r <= tbl_base;
                        tsize_r <= tbl_size;
                        state   <= S_TBL_FETCH;
                    end
                end
                S_TBL_FETCH: begin
                    if (mem_ack) begin
                        entry_r <= mem_rdata;
                        state   <= S_ROOT_CHK;
                    end
                end
                S_ROOT_CHK: begin
                    if (seg_fail || tree_fail) begin
                        pa_r  <= '0;
                        err_r <= seg_fail ? WALK_SEG_ERR : WALK_BAD_TREE;
                        state <= S_REPORT;
                    end else begin
                        shift_r <= shift_next;
                        base_r  <= ev.next_base;
                        idx_r   <= ev.idx_bits;
                        state   <= S_DIR_FETCH;
                    end
                end
                S_DIR_FETCH: begin
                    if (mem_ack) begin
                        entry_r <= mem_rdata;
                        state   <= S_DIR_EVAL;
                    end
                end
                S_DIR_EVAL: begin
                    if (!ev.valid) begin
                        pa_r  <= '0;
                        err_r <= WALK_NO_ENTRY;
                        state <= S_REPORT;
                    end else if (ev.leaf) begin
                        pa_r  <= leaf_addr;
                        err_r <= WALK_OK;
                        state <= S_REPORT;
                    end else if (tree_fail) begin
                        pa_r  <= '0;
                        err_r <= WALK_BAD_TREE;
                        state <= S_REPORT;
                    end else begin
                        shift_r <= shift_next;
                        base_r  <= ev.next_base;
                        idx_r   <= ev.idx_bits;
                        state   <= S_DIR_FETCH;
                    end
                end
                S_REPORT: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == S_IDLE);
        mem_req   = (state == S_TBL_FETCH) || (state == S_DIR_FETCH);
        mem_addr  = (state == S_TBL_FETCH) ? tbl_addr : dir_addr;
        done      = (state == S_REPORT);
        real_addr = pa_r;
        err       = err_r;
    end

endmodule

// File: rtl/radix_walker_checker.sv
module radix_walker_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req,
    input logic [63:0] mem_addr,
    input logic        mem_ack,
    input logic        done,
    input logic [63:0] real_addr,
    input logic [1:0]  err
);
    p_req_held_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_err_zero_pa_r10: assert property (@(posedge clk) disable iff (rst)
        done && (err != 2'd0) |-> real_addr == 64'd0);

    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    p_take_once_r11: assert property (@(posedge clk) disable iff (rst)
        req_ready && req_valid |=> !req_ready);

    p_addr_align_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2:0] == 3'd0) && (mem_addr[63:56] == 8'd0));

endmodule

bind radix_walker radix_walker_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .done      (done),
    .real_addr (real_addr),
    .err       (err)
);

// File: tb/test_radix_walker.sv
module test_radix_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [51:0] req_vpn = '0;
    logic [31:0] req_pid = '0;
    logic [43:0] tbl_base = '0;
    logic [4:0]  tbl_size = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic [63:0] real_addr;
    logic [1:0]  err;

    int total = 0;
    int bad = 0;

    logic [63:0] mem_m [logic [63:0]];
    logic [63:0] flog [8];
    int          nfetch = 0;
    int          lat = 0;
    logic [63:0] got_pa;
    logic [1:0]  got_err;

    always #4 clk = ~clk;

    radix_walker i_radix_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_pid(req_pid), .tbl_base(tbl_base),
        .tbl_size(tbl_size), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
        .real_addr(real_addr), .err(err)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                lat = lat + 1;
                if (lat == 2) begin
                    lat = 0;
                    mem_ack = 1'b1;
                    mem_rdata = mem_m.exists(mem_addr) ? mem_m[mem_addr] : 64'd0;
                    if (nfetch < 8) flog[nfetch] = mem_addr;
                    nfetch = nfetch + 1;
                end
            end
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad = bad + 1;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] root_ent(input logic [4:0] rts,
                                             input logic [63:0] base,
                                             input logic [4:0] ib);
        return ({62'd0, rts[4:3]} << 61) | ({61'd0, rts[2:0]} << 5) |
               (base & 64'h00FF_FFFF_FFFF_FF00) | {59'd0, ib};
    endfunction

    function automatic logic [63:0] dir_ent(input logic [63:0] base, input logic [4:0] ib);
        return 64'h8000_0000_0000_0000 | (base & 64'h00FF_FFFF_FFFF_FF00) | {59'd0, ib};
    endfunction

    function automatic logic [63:0] leaf_ent(input logic [43:0] rpn, input logic [11:0] low);
        return 64'hC000_0000_0000_0000 | {8'd0, rpn, low};
    endfunction

    task automatic clear_mem();
        mem_m.delete();
        nfetch = 0;
    endtask

    task automatic walk(input logic [63:0] va, input logic [31:0] pid,
                        input logic [43:0] tb, input logic [4:0] ts);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_vpn = va[63:12]; req_pid = pid; tbl_base = tb; tbl_size = ts;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n = n + 1;
        end
        got_pa = real_addr;
        got_err = err;
        @(negedge clk);
        chk("R10 done single cycle", {63'd0, done}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R11 ready after reset", {63'd0, req_ready}, 64'd1);
        chk("R10 done low after reset", {63'd0, done}, 64'd0);
        chk("R9 no read after reset", {63'd0, mem_req}, 64'd0);
    endtask

    task automatic t_two_level();
        clear_mem();
        mem_m[64'h10030] = root_ent(5'd0, 64'h20000, 5'd13);
        mem_m[64'h22468] = dir_ent(64'h30000, 5'd6);
        mem_m[64'h30028] = leaf_ent(44'hABCDE, 12'h1A7);
        walk(64'h0000_0000_1234_5678, 32'd3, 44'h10, 5'd0);
        chk("R1 table entry address", flog[0], 64'h10030);
        chk("R6 first directory address", flog[1], 64'h22468);
        chk("R5 R6 second directory address at shift 0", flog[2], 64'h30028);
        chk("R9 read count", 64'(nfetch), 64'd3);
        chk("R8 leaf real address", got_pa, 64'hABCDE1A7);
        chk("R10 ok code", {62'd0, got_err}, 64'd0);
    endtask

    task automatic t_table_mask();
        clear_mem();
        walk(64'h0000_0000_1234_5678, 32'h0000_0523, 44'h100, 5'd4);
        chk("R1 size-masked table address", flog[0], 64'h105230);
        chk("R4 zero index width bad tree", {62'd0, got_err}, 64'd2);
        chk("R10 zero address on error", got_pa, 64'd0);
    endtask

    task automatic t_pid_force();
        clear_mem();
        mem_m[64'h10000] = root_ent(5'd0, 64'h20000, 5'd4);
        mem_m[64'h10030] = root_ent(5'd0, 64'h20000, 5'd13);
        walk(64'hC000_0000_0000_0000, 32'd3, 44'h10, 5'd0);
        chk("R2 pid forced zero address", flog[0], 64'h10000);
        chk("R2 entry from zero pid slot", {62'd0, got_err}, 64'd2);
    endtask

    task automatic t_segment();
        clear_mem();
        mem_m[64'h10030] = root_ent(5'd0, 64'h20000, 5'd13);
        walk(64'h8000_0000_0000_0000, 32'd3, 44'h10, 5'd0);
        chk("R3 top bits differ", {62'd0, got_err}, 64'd1);
        chk("R3 one read only", 64'(nfetch), 64'd1);
        clear_mem();
        mem_m[64'h10030] = root_ent(5'd9, 64'h20000, 5'd13);
        walk(64'h0000_0100_0000_0000, 32'd3, 44'h10, 5'd0);
        chk("R3 bit 40 outside size 9", {62'd0, got_err}, 64'd1);
        clear_mem();
        mem_m[64'h10030] = root_ent(5'd10, 64'h20000, 5'd13);
        walk(64'h0000_0100_0000_0000, 32'd3, 44'h10, 5'd0);
        chk("R3 bit 40 inside size 10", {62'd0, got_err}, 64'd3);
    endtask

    task automatic t_bounds();
        clear_mem();
        mem_m[64'h10030] = root_ent(5'd0, 64'h20000, 5'd17);
        walk(64'h0000_0000_1234_5678, 32'd3, 44'h10, 5'd0);
        chk("R4 root width 17", {62'd0, got_err}, 64'd2);
        clear_mem();
        mem_m[64'h10030] = root_ent(5'd0, 64'h20000, 5'd16);
        walk(64'h0000_0000_1234_5678, 32'd3, 44'h10, 5'd0);
        chk("R4 root width 16 accepted", {62'd0, got_err}, 64'd3);
        clear_mem();
        mem_m[64'h10030] = root_ent(5'd0, 64'h20000, 5'd13);
        mem_m[64'h22468] = dir_ent(64'h30000, 5'd7);
        walk(64'h0000_0000_1234_5678, 32'd3, 44'h10, 5'd0);
        chk("R4 level width above shift", {62'd0, got_err}, 64'd2);
        chk("R4 no read after bad level", 64'(nfetch), 64'd2);
    endtask

    task automatic t_invalid();
        clear_mem();
        mem_m[64'h10030] = root_ent(5'd0, 64'h20000, 5'd13);
        mem_m[64'h22468] = 64'h4000_0000_000A_B000;
        walk(64'h0000_0000_1234_5678, 32'd3, 44'h10, 5'd0);
        chk("R7 invalid entry no-entry code", {62'd0, got_err}, 64'd3);
        chk("R7 invalid entry zero address", got_pa, 64'd0);
    endtask

    task automatic t_large_page();
        clear_mem();
        mem_m[64'h10030] = root_ent(5'd0, 64'h20000, 5'd13);
        mem_m[64'h22468] = leaf_ent(44'hABC00, 12'h00F);
        walk(64'h0000_0000_1234_5678, 32'd3, 44'h10, 5'd0);
        chk("R8 R5 leaf merged under shift 6", got_pa, 64'hABC0500F);
        chk("R7 leaf after one directory read", 64'(nfetch), 64'd2);
    endtask

    task automatic t_busy();
        logic seen_ready;
        clear_mem();
        mem_m[64'h10030] = root_ent(5'd0, 64'h20000, 5'd13);
        mem_m[64'h22468] = dir_ent(64'h30000, 5'd6);
        mem_m[64'h30028] = leaf_ent(44'hABCDE, 12'h1A7);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_vpn = 52'h0_0000_0001_2345; req_pid = 32'd3; tbl_base = 44'h10; tbl_size = 5'd0;
        req_valid = 1'b1;
        @(negedge clk);
        req_vpn = 52'h8_0000_0000_0000; req_pid = 32'd7;
        seen_ready = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (req_ready) seen_ready = 1'b1;
        end
        req_valid = 1'b0;
        chk("R11 not ready while busy", {63'd0, seen_ready}, 64'd0);
        while (!done) @(negedge clk);
        chk("R11 walk unaffected by busy request", real_addr, 64'hABCDE1A7);
        chk("R11 table read not redirected", flog[0], 64'h10030);
        @(negedge clk);
        chk("R11 ready again after walk", {63'd0, req_ready}, 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_two_level();
        t_table_mask();
        t_pid_force();
        t_segment();
        t_bounds();
        t_invalid();
        t_large_page();
        t_busy();
        summary();
        $finish;
    end

endmodule